// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a bitstream into a target programmable device over a two-wire serial configuration link. A `start` pulse begins the sequence. The sequencer pulls the active-low configuration request low for a fixed reset pulse and confirms that the target reports reset on its active-low status pin. It then releases the request and polls status at a fixed interval until the target reports ready. After a settle delay it shifts bytes taken from a valid/ready stream onto the serial clock and data pins.

After the byte marked last, the sequencer reads status and configuration-done. If both show success, it sends one byte of zero-data clocks so the target can enter user mode, and then reports `done`. Any failure reports `error` with a code. A request flagged as partial reconfiguration is refused at once.

All delays come from a microsecond timebase built from the system clock by the `CLK_PER_US` divider. A `profileExt` input picks the longer readiness timeout and the longer settle time. The status and configuration-done inputs are synchronised before use.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `cfgReqN`=1, `sclk`=0, `inReady`=0, `done`=0, `error`=0 and `errCode`=0.
- R2: A `start` with `partialReq`=1 gives `error`=1 and `errCode`=1 within two cycles. `cfgReqN` never goes low and `sclk` never toggles.
- R3: On a normal `start`, `cfgReqN` goes low for RESET_US microseconds (8 cycles by default) and then returns high. If `tgtStatusN` is high when the pulse ends, the result is `errCode`=2, with no serial clocks and no `inReady`.
- R4: After release, `tgtStatusN` is sampled once every POLL_US (268) microseconds. If it is still low after ceil(max wait / POLL_US) samples, the result is `errCode`=3. That is 6 samples (6432 cycles) in the default profile with a 1506 µs maximum, and 12 samples (12864 cycles) in the extended profile with a 3000 µs maximum.
- R5: Once a sample reads `tgtStatusN` high, `inReady` first rises after a settle time of 2 µs (default) or 10 µs (extended). With the default divider this is 1080 or 1112 cycles after `cfgReqN` rises.
- R6: With `lsbFirst`=0, each byte is sent bit 0 first. With `lsbFirst`=1, the byte is sent as given, bit 7 first.
- R7: `sdata` changes only while `sclk` is low, so it is stable across every high phase. `sclk` idles low.
- R8: `inReady` is low while a byte is being shifted. Each accepted byte gives exactly 8 rising `sclk` edges. `inLast` marks the final byte.
- R9: If `tgtStatusN` is low after the last byte, the result is `errCode`=4 and no trailing clocks are sent.
- R10: With USE_DONE=1, if `tgtConfDone` is low after the last byte, the result is `errCode`=5 and no trailing clocks are sent.
- R11: On success, 8 trailing `sclk` rises carry `sdata`=0, and then `done`=1 with `errCode`=0.
- R12: `done` and `error` are never both high. The result holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (pulse, accepted when idle) |
| partialReq | input | 1 | Run is a partial reconfiguration request (refused) |
| lsbFirst | input | 1 | Stream bytes are already in transmit order |
| profileExt | input | 1 | Select extended timing profile |
| inData | input | 8 | Bitstream byte |
| inValid | input | 1 | `inData` holds a byte |
| inLast | input | 1 | Current byte is the final one |
| inReady | output | 1 | Sequencer accepts a byte this cycle |
| tgtStatusN | input | 1 | Target status, low means reset or fault |
| tgtConfDone | input | 1 | Target configuration-done indication |
| cfgReqN | output | 1 | Active-low configuration request to the target |
| sclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| done | output | 1 | Run completed successfully |
| error | output | 1 | Run failed |
| errCode | output | 3 | Failure cause: 0 none, 1 partial, 2 no reset, 3 not ready, 4 config fault, 5 no done |

## Verification
A wrong microsecond count or poll limit moves the first `inReady` or the timeout `error` by whole multiples of 4 or 1072 cycles. Each run measures these exactly against the release of `cfgReqN`. A wrong bit order or a wrong shift count shows up as soon as the first byte appears on `sdata`. A broken completion check shows within one trailing byte, as missing or extra clocks or the wrong result code. A failure to refuse a partial request shows as `cfgReqN` going low one cycle after `start`.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_PARTIAL   = 3'd1,
    ERR_NO_RESET  = 3'd2,
    ERR_NOT_READY = 3'd3,
    ERR_CONFIG    = 3'd4,
    ERR_NO_DONE   = 3'd5
  } errCode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_POLL, ST_SETTLE, ST_FETCH, ST_SHIFT, ST_CHECK, ST_TRAIL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;
    logic loadTrail;
    logic keepOrder;
  } shiftCmd_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift
  import ps_cfg_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCmd_t         cmd,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              shiftDone
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int PH_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [BYTE_W-1:0] revByte, pickByte, shReg;
  logic [BIT_W-1:0]  bitsLeft;
  logic [PH_W-1:0]   phCnt;
  logic              phEnd, trailQ;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign revByte[g] = byteIn[BYTE_W-1-g];
  end

  always_comb begin
    if (cmd.loadTrail)      pickByte = '0;
    else if (cmd.keepOrder) pickByte = byteIn;
    else                    pickByte = revByte;
  end

  assign phEnd = (phCnt == PH_W'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk      <= 1'b0;
      sdata     <= 1'b0;
      busy      <= 1'b0;
      shiftDone <= 1'b0;
      shReg     <= '0;
      bitsLeft  <= '0;
      phCnt     <= '0;
      trailQ    <= 1'b0;
    end else begin
      shiftDone <= 1'b0;
      if (cmd.loadByte || cmd.loadTrail) begin
        sdata    <= pickByte[BYTE_W-1];
        shReg    <= {pickByte[BYTE_W-2:0], 1'b0};
        bitsLeft <= BIT_W'(BYTE_W - 1);
        phCnt    <= '0;
        sclk     <= 1'b0;
        busy     <= 1'b1;
        trailQ   <= cmd.loadTrail;
      end else if (busy) begin
        phCnt <= phEnd ? '0 : phCnt + 1'b1;
        if (phEnd) begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitsLeft == '0) begin
              busy      <= 1'b0;
              shiftDone <= 1'b1;
            end else begin
              // next bit placed on the falling edge
              sdata    <= shReg[BYTE_W-1];
              shReg    <= {shReg[BYTE_W-2:0], 1'b0};
              bitsLeft <= bitsLeft - 1'b1;
            end
          end
        end
      end
    end
  end

  // R7: data held while the serial clock is high
  a_r7_data_held_high: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(sdata));
  // R11: trailing clocks carry zero data
  a_r11_trail_zero: assert property (@(posedge clk) disable iff (!rstN)
    (trailQ && sclk) |-> !sdata);
  // R8: no new load while a byte is in flight
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadByte || cmd.loadTrail) |-> !busy);

endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int RESET_US    = 2,
  parameter int POLL_US     = 268,
  parameter int MAXWAIT_STD = 1506,
  parameter int MAXWAIT_EXT = 3000,
  parameter int SETTLE_STD  = 2,
  parameter int SETTLE_EXT  = 10,
  parameter bit USE_DONE    = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      partialReq,
  input  logic      lsbFirst,
  input  logic      profileExt,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      statusNSync,
  input  logic      confDoneSync,
  input  logic      shiftBusy,
  input  logic      shiftDone,
  output shiftCmd_t cmd,
  output logic      inReady,
  output logic      cfgReqN,
  output logic      done,
  output logic      error,
  output errCode_e  errCode
);
  localparam int POLLS_STD = ceilDiv(MAXWAIT_STD, POLL_US);
  localparam int POLLS_EXT = ceilDiv(MAXWAIT_EXT, POLL_US);
  localparam int POLLS_MAX = (POLLS_EXT > POLLS_STD) ? POLLS_EXT : POLLS_STD;
  localparam int PC_W      = $clog2(POLLS_MAX + 1);
  localparam int TMR_MAX   = RESET_US + POLL_US + SETTLE_STD + SETTLE_EXT;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int PRE_W     = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  seqState_e        state;
  logic [PRE_W-1:0] preCnt;
  logic [TMR_W-1:0] usLeft;
  logic [PC_W-1:0]  pollCnt, pollLim;
  logic             usTick, tmrExpire, profQ, orderQ, lastQ, checkPass;

  assign usTick    = (preCnt == PRE_W'(CLK_PER_US - 1));
  assign tmrExpire = usTick && (usLeft == TMR_W'(1));
  assign pollLim   = profQ ? PC_W'(POLLS_EXT) : PC_W'(POLLS_STD);
  assign checkPass = statusNSync && (confDoneSync || !USE_DONE);

  assign inReady       = (state == ST_FETCH);
  assign cmd.loadByte  = (state == ST_FETCH) && inValid;
  assign cmd.loadTrail = (state == ST_CHECK) && checkPass;
  assign cmd.keepOrder = orderQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      usLeft  <= '0;
      pollCnt <= '0;
      profQ   <= 1'b0;
      orderQ  <= 1'b0;
      lastQ   <= 1'b0;
      cfgReqN <= 1'b1;
      done    <= 1'b0;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      preCnt <= usTick ? '0 : preCnt + 1'b1;
      if (usTick && usLeft != '0) usLeft <= usLeft - 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          done <= 1'b0;
          if (partialReq) begin
            error   <= 1'b1;
            errCode <= ERR_PARTIAL;
          end else begin
            error   <= 1'b0;
            errCode <= ERR_NONE;
            profQ   <= profileExt;
            orderQ  <= lsbFirst;
            cfgReqN <= 1'b0;
            usLeft  <= TMR_W'(RESET_US);
            preCnt  <= '0;
            state   <= ST_RST;
          end
        end
        ST_RST: if (tmrExpire) begin
          cfgReqN <= 1'b1;
          if (statusNSync) begin
            error   <= 1'b1;
            errCode <= ERR_NO_RESET;
            state   <= ST_IDLE;
          end else begin
            usLeft  <= TMR_W'(POLL_US);
            preCnt  <= '0;
            pollCnt <= '0;
            state   <= ST_POLL;
          end
        end
        ST_POLL: if (tmrExpire) begin
          if (statusNSync) begin
            usLeft <= profQ ? TMR_W'(SETTLE_EXT) : TMR_W'(SETTLE_STD);
            preCnt <= '0;
            state  <= ST_SETTLE;
          end else if (pollCnt == pollLim - 1'b1) begin
            error   <= 1'b1;
            errCode <= ERR_NOT_READY;
            state   <= ST_IDLE;
          end else begin
            pollCnt <= pollCnt + 1'b1;
            usLeft  <= TMR_W'(POLL_US);
            preCnt  <= '0;
          end
        end
        ST_SETTLE: if (tmrExpire) state <= ST_FETCH;
        ST_FETCH: if (inValid) begin
          lastQ <= inLast;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (shiftDone) state <= lastQ ? ST_CHECK : ST_FETCH;
        ST_CHECK: begin
          if (checkPass) begin
            state <= ST_TRAIL;
          end else begin
            error   <= 1'b1;
            errCode <= !statusNSync ? ERR_CONFIG : ERR_NO_DONE;
            state   <= ST_IDLE;
          end
        end
        ST_TRAIL: if (shiftDone) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: request released whenever the sequencer is idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> cfgReqN);
  // R2: partial request refused without touching the request line
  a_r2_partial_refused: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && partialReq) |=> (cfgReqN && error && errCode == ERR_PARTIAL));
  // R12: results are exclusive
  a_r12_done_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));
  // R8: stream only ready while the shifter is idle
  a_r8_ready_idle_shifter: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !shiftBusy);
  // R4: poll count stays inside the profile limit
  a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL) |-> (pollCnt < pollLim));

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int SCLK_HALF   = 2,
  parameter int RESET_US    = 2,
  parameter int POLL_US     = 268,
  parameter int MAXWAIT_STD = 1506,
  parameter int MAXWAIT_EXT = 3000,
  parameter int SETTLE_STD  = 2,
  parameter int SETTLE_EXT  = 10,
  parameter bit USE_DONE    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       partialReq,
  input  logic       lsbFirst,
  input  logic       profileExt,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  input  logic       tgtStatusN,
  input  logic       tgtConfDone,
  output logic       cfgReqN,
  output logic       sclk,
  output logic       sdata,
  output logic       done,
  output logic       error,
  output logic [2:0] errCode
);
  logic [1:0] statusSync, doneSync;
  shiftCmd_t  cmd;
  logic       shiftBusy, shiftDone;
  errCode_e   codeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusSync <= 2'b11;
      doneSync   <= 2'b00;
    end else begin
      statusSync <= {statusSync[0], tgtStatusN};
      doneSync   <= {doneSync[0], tgtConfDone};
    end
  end

  ps_cfg_ctrl #(
    .CLK_PER_US(CLK_PER_US), .RESET_US(RESET_US), .POLL_US(POLL_US),
    .MAXWAIT_STD(MAXWAIT_STD), .MAXWAIT_EXT(MAXWAIT_EXT),
    .SETTLE_STD(SETTLE_STD), .SETTLE_EXT(SETTLE_EXT), .USE_DONE(USE_DONE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .partialReq(partialReq),
    .lsbFirst(lsbFirst), .profileExt(profileExt), .inValid(inValid),
    .inLast(inLast), .statusNSync(statusSync[1]), .confDoneSync(doneSync[1]),
    .shiftBusy(shiftBusy), .shiftDone(shiftDone), .cmd(cmd), .inReady(inReady),
    .cfgReqN(cfgReqN), .done(done), .error(error), .errCode(codeQ)
  );

  ps_cfg_shift #(.BYTE_W(8), .SCLK_HALF(SCLK_HALF)) i_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .byteIn(inData),
    .sclk(sclk), .sdata(sdata), .busy(shiftBusy), .shiftDone(shiftDone)
  );

  assign errCode = codeQ;

endmodule

// File: tb/test_ps_cfg_loader.sv
module test_ps_cfg_loader;
  localparam time CLK_PERIOD = 10ns;
  localparam int  POLL_CYC   = 268 * 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, partialReq = 0, lsbFirst = 0, profileExt = 0;
  logic [7:0] inData = '0;
  logic inValid = 0, inLast = 0, tgtStatusN = 0, tgtConfDone = 0;
  logic inReady, cfgReqN, sclk, sdata, done, error;
  logic [2:0] errCode;

  int checks = 0, failures = 0, cycles = 0;
  int capCnt = 0, holdErr = 0, readyBusyErr = 0, cfgLowCnt = 0, readySeen = 0;
  logic capBits [0:255];
  logic prevSclk = 1'b0, heldBit = 1'b0;
  logic [7:0] txB [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_loader i_ps_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .partialReq(partialReq),
    .lsbFirst(lsbFirst), .profileExt(profileExt), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .tgtStatusN(tgtStatusN), .tgtConfDone(tgtConfDone), .cfgReqN(cfgReqN),
    .sclk(sclk), .sdata(sdata), .done(done), .error(error), .errCode(errCode)
  );

  always @(negedge clk) begin
    cycles++;
    if (sclk && !prevSclk) begin
      if (capCnt < 256) capBits[capCnt] = sdata;
      capCnt++;
      heldBit = sdata;
    end else if (sclk && sdata !== heldBit) holdErr++;
    if (inReady && sclk) readyBusyErr++;
    if (inReady) readySeen++;
    if (cfgReqN === 1'b0) cfgLowCnt++;
    prevSclk = sclk;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    capCnt = 0; holdErr = 0; readyBusyErr = 0; cfgLowCnt = 0; readySeen = 0;
  endtask

  task automatic pulseStart(input bit part, input bit lsb, input bit ext);
    @(negedge clk);
    start = 1; partialReq = part; lsbFirst = lsb; profileExt = ext;
    @(negedge clk);
    start = 0; partialReq = 0;
  endtask

  task automatic tReset();
    chk("R1 cfgReqN", cfgReqN === 1'b1, cfgReqN, 1);
    chk("R1 sclk", sclk === 1'b0, sclk, 0);
    chk("R1 inReady", inReady === 1'b0, inReady, 0);
    chk("R1 done/error", done === 1'b0 && error === 1'b0, {done, error}, 0);
    chk("R1 errCode", errCode === 3'd0, errCode, 0);
  endtask

  task automatic tPartial();
    clearMon();
    pulseStart(1, 0, 0);
    chk("R2 error code", error === 1'b1 && errCode === 3'd1, errCode, 1);
    repeat (20) @(negedge clk);
    chk("R2 request untouched", cfgLowCnt == 0, cfgLowCnt, 0);
    chk("R2 no clocks", capCnt == 0, capCnt, 0);
  endtask

  task automatic tNoReset();
    clearMon();
    tgtStatusN = 1;
    repeat (4) @(negedge clk);
    pulseStart(0, 0, 0);
    chk("R12 old result cleared", error === 1'b0, error, 0);
    while (!error) @(negedge clk);
    chk("R3 pulse length", cfgLowCnt == 8, cfgLowCnt, 8);
    chk("R3 code no reset", errCode === 3'd2, errCode, 2);
    repeat (10) @(negedge clk);
    chk("R3 no clocks/ready", capCnt == 0 && readySeen == 0, capCnt + readySeen, 0);
    chk("R3 released", cfgReqN === 1'b1, cfgReqN, 1);
  endtask

  task automatic tTimeout(input bit ext);
    int n, exp;
    clearMon();
    tgtStatusN = 0;
    repeat (4) @(negedge clk);
    pulseStart(0, 0, ext);
    while (cfgReqN !== 1'b0) @(negedge clk);
    while (cfgReqN !== 1'b1) @(negedge clk);
    n = 0;
    while (!error) begin @(negedge clk); n++; end
    exp = (ext ? 12 : 6) * POLL_CYC;
    chk(ext ? "R4 ext timeout time" : "R4 std timeout time", n == exp, n, exp);
    chk("R4 code not ready", errCode === 3'd3, errCode, 3);
    chk("R4 no clocks", capCnt == 0, capCnt, 0);
  endtask

  task automatic tLoad(input bit ext, input bit lsb, input int nB,
                       input bit endStat, input bit endDone, input int expCode);
    int n, exp, bad, expBits;
    clearMon();
    tgtStatusN = 0; tgtConfDone = 0;
    repeat (4) @(negedge clk);
    pulseStart(0, lsb, ext);
    while (cfgReqN !== 1'b0) @(negedge clk);
    while (cfgReqN !== 1'b1) @(negedge clk);
    n = 0;
    while (!inReady) begin
      @(negedge clk); n++;
      if (n == 10) tgtStatusN = 1;
    end
    exp = POLL_CYC + (ext ? 40 : 8);
    chk("R5 settle timing", n == exp, n, exp);
    chk("R3 pulse length", cfgLowCnt == 8, cfgLowCnt, 8);
    for (int i = 0; i < nB; i++) begin
      inData = txB[i]; inValid = 1; inLast = (i == nB - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 0; inLast = 0;
    tgtStatusN = endStat; tgtConfDone = endDone;
    while (!(done || error)) @(negedge clk);
    repeat (3) @(negedge clk);
    expBits = nB * 8 + (expCode == 0 ? 8 : 0);
    chk("R8 clock count", capCnt == expBits, capCnt, expBits);
    bad = 0;
    for (int i = 0; i < nB; i++)
      for (int j = 0; j < 8; j++)
        if (capBits[i*8+j] !== (lsb ? txB[i][7-j] : txB[i][j])) bad++;
    chk("R6 bit order", bad == 0, bad, 0);
    chk("R7 data stable while high", holdErr == 0, holdErr, 0);
    chk("R8 ready low while shifting", readyBusyErr == 0, readyBusyErr, 0);
    chk("R9 R10 R11 result code", errCode === 3'(expCode), errCode, expCode);
    if (expCode == 0) begin
      bad = 0;
      for (int j = 0; j < 8; j++) if (capBits[nB*8+j] !== 1'b0) bad++;
      chk("R11 trailing zeros", bad == 0, bad, 0);
      chk("R11 done", done === 1'b1 && error === 1'b0, {done, error}, 2);
    end else begin
      chk("R9 R10 error flag", error === 1'b1 && done === 1'b0, {done, error}, 1);
    end
    repeat (30) @(negedge clk);
    chk("R12 result held", (expCode == 0) ? done === 1'b1 : error === 1'b1, done, expCode == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tPartial();
    tNoReset();
    tTimeout(0);
    tTimeout(1);
    txB[0] = 8'h01; txB[1] = 8'hC3; txB[2] = 8'h5E; txB[3] = 8'h80;
    tLoad(0, 0, 4, 1, 1, 0);     // R6 R11 default profile, reversed order
    txB[0] = 8'h35; txB[1] = 8'hF0; txB[2] = 8'h0A;
    tLoad(1, 1, 3, 1, 1, 0);     // R6 R5 extended profile, order kept
    txB[0] = 8'h96; txB[1] = 8'h2C;
    tLoad(0, 0, 2, 0, 1, 4);     // R9 status fault
    txB[0] = 8'h7B;
    tLoad(1, 0, 1, 1, 0, 5);     // R10 missing configuration-done
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule